// File: doc/BRIEF.md
# Prescaled Up/Down General-Purpose Timer

This block is a 16-bit timer that runs on the bus clock and is controlled through a small register set. A two-bit prescaler code and a fast-select bit choose how many bus clocks make one counter step: 1, 4, 16, 64 or 256. The counter counts either up or down. In periodic mode it restarts from a programmed load value each time it expires. In free-running mode it rolls over to the opposite end of its range. Every expiry raises a timeout interrupt.

A rising edge on the capture input stores the current counter value in a capture register and raises a capture interrupt. Software clears each interrupt on its own by writing a one to its bit in the clear register. Counting only happens while both the external enable pin and the run bit in the control register are high.

Register word addresses:

| Address | Register | Access | Contents |
|---|---|---|---|
| 0 | CTRL | read/write | bits [1:0] prescaler code, bit 2 count up, bit 3 periodic, bit 4 run, bit 15 fast |
| 1 | LOAD | read/write | load value |
| 2 | COUNT | read-only | counter value |
| 3 | CLEAR | write-only | bit 0 clears timeout, bit 1 clears capture; reads as 0 |
| 4 | STATUS | read-only | bit 0 timeout flag, bit 1 capture flag |
| 5 | CAPTURE | read-only | captured counter value |

Bits of CTRL not listed above read as 0.

Top module: `gp_timer`

## Requirements
- R1: After reset, CTRL reads 0x0002 (prescaler code 2, count down, free-running, stopped, fast clear). LOAD, COUNT and CAPTURE read 0, and both interrupt outputs are low.
- R2: The counter steps once every N active clocks. N is 16 for code 01, 64 for code 10 and 256 for code 11. For code 00, N is 1 when CTRL bit 15 is set and 4 when it is clear. Writing CTRL or LOAD restarts the prescaler.
- R3: With CTRL bit 2 = 0, the counter decrements. A step taken from 0x0000 is an expiry and sets the timeout flag, which drives irq_tmo.
- R4: With CTRL bit 2 = 1, the counter increments. A step taken from 0xFFFF is an expiry and sets the timeout flag.
- R5: With CTRL bit 3 = 1, an expiry reloads the counter from LOAD.
- R6: With CTRL bit 3 = 0, an expiry wraps the counter to 0xFFFF when counting down, or to 0x0000 when counting up.
- R7: A write to LOAD also copies the value into the counter. Writes to COUNT have no effect.
- R8: The counter and the prescaler hold their values unless the tmr_en pin and CTRL bit 4 are both 1.
- R9: A rising edge of cap_in copies the counter value into CAPTURE and sets the capture flag, which drives irq_cap. A level held high does not capture again.
- R10: A write of 1 to CLEAR bit 0 clears only the timeout flag. A write of 1 to CLEAR bit 1 clears only the capture flag. Zero bits have no effect.
- R11: When a clear and a new event for the same flag occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the timer runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | External count enable |
| cap_in | input | 1 | Capture event; its rising edge triggers a capture |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| irq_tmo | output | 1 | Timeout interrupt flag |
| irq_cap | output | 1 | Capture interrupt flag |

## Verification
A wrong prescaler count moves the first counter step away from the expected clock. This shows in COUNT within one prescaler period, so the bench reads COUNT on the clock just before the expected step and on the clock of the step. A wrong expiry compare or reload path shows on irq_tmo and COUNT in the same cycle as the boundary step. A broken edge detector or a broken clear priority shows on irq_cap and CAPTURE one clock after the stimulus.

// File: rtl/gp_timer.sv
`timescale 1ns/1ps
module gp_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tmr_en,
  input  logic         cap_in,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [2:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         irq_tmo,
  output logic         irq_cap
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic [1:0]   presc;
  logic         up, periodic, run, fast;
  logic [W-1:0] load_q, cnt_q, capt_q, cnt_nxt;
  logic [7:0]   pre_q, pre_lim;
  logic         cap_d, tmo_q, capf_q;

  wire wr       = bus_sel & bus_wr;
  wire wr_ctrl  = wr && bus_addr == 3'd0;
  wire wr_load  = wr && bus_addr == 3'd1;
  wire wr_clr   = wr && bus_addr == 3'd3;
  wire active   = tmr_en & run;
  wire tick     = active && pre_q == pre_lim;
  wire at_end   = up ? (cnt_q == ALL1) : (cnt_q == '0);
  wire expire   = tick & at_end;
  wire cap_rise = cap_in & ~cap_d;

  always_comb begin
    case (presc)
      2'b00:   pre_lim = fast ? 8'd0 : 8'd3;
      2'b01:   pre_lim = 8'd15;
      2'b10:   pre_lim = 8'd63;
      default: pre_lim = 8'd255;
    endcase
  end

  always_comb begin
    if (at_end)  cnt_nxt = periodic ? load_q : (up ? '0 : ALL1);
    else if (up) cnt_nxt = cnt_q + 1'b1;
    else         cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc    <= 2'b10;
      up       <= 1'b0;
      periodic <= 1'b0;
      run      <= 1'b0;
      fast     <= 1'b0;
      load_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        presc    <= bus_wdata[1:0];
        up       <= bus_wdata[2];
        periodic <= bus_wdata[3];
        run      <= bus_wdata[4];
        fast     <= bus_wdata[15];
      end
      if (wr_load) load_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ctrl || wr_load) pre_q <= '0;
      else if (active)        pre_q <= tick ? 8'd0 : pre_q + 8'd1;
      if (wr_load)            cnt_q <= bus_wdata;
      else if (tick)          cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_d  <= 1'b0;
      capt_q <= '0;
      tmo_q  <= 1'b0;
      capf_q <= 1'b0;
    end else begin
      cap_d  <= cap_in;
      if (cap_rise) capt_q <= cnt_q;
      tmo_q  <= expire   | (tmo_q  & ~(wr_clr & bus_wdata[0]));
      capf_q <= cap_rise | (capf_q & ~(wr_clr & bus_wdata[1]));
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      3'd0: begin
        bus_rdata[1:0] = presc;
        bus_rdata[2]   = up;
        bus_rdata[3]   = periodic;
        bus_rdata[4]   = run;
        bus_rdata[W-1] = fast;
      end
      3'd1: bus_rdata = load_q;
      3'd2: bus_rdata = cnt_q;
      3'd4: begin
        bus_rdata[0] = tmo_q;
        bus_rdata[1] = capf_q;
      end
      3'd5: bus_rdata = capt_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_tmo = tmo_q;
  assign irq_cap = capf_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !wr_load) |=> $stable(cnt_q));
  p_pre_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !wr_load && !wr_ctrl) |=> $stable(pre_q));
  p_tmo_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq_tmo);
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic && !wr_load) |=> cnt_q == $past(load_q));
  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise |=> (irq_cap && capt_q == $past(cnt_q)));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && bus_wdata[0] && !expire) |=> !irq_tmo);
  p_down_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !up && cnt_q != '0 && !wr_load) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: tb/gp_timer_tb_top.sv
`timescale 1ns/1ps
module gp_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tmr_en = 1'b0, cap_in = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic irq_tmo, irq_cap;
  int checks = 0, errors = 0;
  bit done = 0;

  gp_timer dut_i (.clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .cap_in(cap_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_tmo(irq_tmo), .irq_cap(irq_cap));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(3'd0, v); chk("R1 ctrl", v, 16'h0002);
    rd(3'd1, v); chk("R1 load", v, 16'h0000);
    rd(3'd2, v); chk("R1 count", v, 16'h0000);
    rd(3'd5, v); chk("R1 capture", v, 16'h0000);
    chk("R1 irqs", {14'd0, irq_cap, irq_tmo}, 16'h0000);
  endtask

  task automatic t_down_periodic;
    logic [15:0] v;
    tmr_en = 0;
    wr(3'd1, 16'd5);
    rd(3'd2, v); chk("R7 load copies to count", v, 16'd5);
    wr(3'd0, 16'h8018);
    tmr_en = 1; step(5);
    rd(3'd2, v); chk("R3 down to zero", v, 16'd0);
    chk("R3 no timeout before expiry", {15'd0, irq_tmo}, 16'd0);
    step(1); tmr_en = 0;
    rd(3'd2, v); chk("R5 reload", v, 16'd5);
    chk("R3 timeout", {15'd0, irq_tmo}, 16'd1);
  endtask

  task automatic t_clear;
    logic [15:0] v;
    tmr_en = 0;
    cap_in = 1; step(1); cap_in = 0;
    wr(3'd3, 16'h0000);
    rd(3'd4, v); chk("R10 zero write", v, 16'h0003);
    wr(3'd3, 16'h0002);
    rd(3'd4, v); chk("R10 clear capture only", v, 16'h0001);
    wr(3'd3, 16'h0001);
    rd(3'd4, v); chk("R10 clear timeout", v, 16'h0000);
  endtask

  task automatic t_free_down;
    logic [15:0] v;
    tmr_en = 0;
    wr(3'd1, 16'd0); wr(3'd0, 16'h8010);
    tmr_en = 1; step(1); tmr_en = 0;
    rd(3'd2, v); chk("R6 down wrap", v, 16'hFFFF);
    chk("R3 timeout free", {15'd0, irq_tmo}, 16'd1);
    wr(3'd3, 16'h0001);
  endtask

  task automatic t_up;
    logic [15:0] v;
    tmr_en = 0;
    wr(3'd1, 16'hFFFD); wr(3'd0, 16'h801C);
    tmr_en = 1; step(2);
    rd(3'd2, v); chk("R4 up to max", v, 16'hFFFF);
    chk("R4 no early timeout", {15'd0, irq_tmo}, 16'd0);
    step(1); tmr_en = 0;
    rd(3'd2, v); chk("R5 up reload", v, 16'hFFFD);
    chk("R4 timeout", {15'd0, irq_tmo}, 16'd1);
    wr(3'd3, 16'h0001);
    wr(3'd1, 16'hFFFF); wr(3'd0, 16'h8014);
    tmr_en = 1; step(1); tmr_en = 0;
    rd(3'd2, v); chk("R6 up wrap", v, 16'h0000);
    chk("R4 timeout free", {15'd0, irq_tmo}, 16'd1);
    wr(3'd3, 16'h0001);
  endtask

  task automatic t_presc(input logic [1:0] code, input logic fast, input int div);
    logic [15:0] v;
    tmr_en = 0;
    wr(3'd1, 16'd100);
    wr(3'd0, {fast, 10'd0, 3'b100, code});
    tmr_en = 1; step(div - 1);
    rd(3'd2, v); chk("R2 before step", v, 16'd100);
    step(1); tmr_en = 0;
    rd(3'd2, v); chk("R2 on step", v, 16'd99);
  endtask

  task automatic t_enable;
    logic [15:0] v;
    tmr_en = 0;
    wr(3'd1, 16'd100); wr(3'd0, 16'h0000);
    tmr_en = 1; step(10);
    rd(3'd2, v); chk("R8 run bit clear holds", v, 16'd100);
    tmr_en = 0;
    wr(3'd0, 16'h0010);
    step(10);
    rd(3'd2, v); chk("R8 pin low holds", v, 16'd100);
    tmr_en = 1; step(2); tmr_en = 0; step(10); tmr_en = 1; step(1);
    rd(3'd2, v); chk("R8 prescaler held", v, 16'd100);
    step(1); tmr_en = 0;
    rd(3'd2, v); chk("R8 prescaler resumed", v, 16'd99);
    wr(3'd2, 16'h1234);
    rd(3'd2, v); chk("R7 count read-only", v, 16'd99);
  endtask

  task automatic t_capture;
    logic [15:0] v;
    tmr_en = 0;
    wr(3'd1, 16'd50); wr(3'd0, 16'h8010);
    cap_in = 1; step(1);
    rd(3'd5, v); chk("R9 capture value", v, 16'd50);
    chk("R9 capture flag", {15'd0, irq_cap}, 16'd1);
    tmr_en = 1; step(3); tmr_en = 0;
    rd(3'd5, v); chk("R9 level no recapture", v, 16'd50);
    cap_in = 0;
    wr(3'd3, 16'h0002);
    chk("R10 capture cleared", {15'd0, irq_cap}, 16'd0);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'd3; bus_wdata = 16'h0002; cap_in = 1;
    step(1);
    bus_sel = 0; bus_wr = 0; cap_in = 0;
    chk("R11 event wins over clear", {15'd0, irq_cap}, 16'd1);
    rd(3'd5, v); chk("R9 capture running value", v, 16'd47);
    wr(3'd3, 16'h0002);
  endtask

  initial begin
    step(3); rst_n = 1; step(1);
    t_reset;
    t_down_periodic;
    t_clear;
    t_free_down;
    t_up;
    t_presc(2'b00, 1'b1, 1);
    t_presc(2'b00, 1'b0, 4);
    t_presc(2'b01, 1'b0, 16);
    t_presc(2'b10, 1'b0, 64);
    t_presc(2'b11, 1'b1, 256);
    t_enable;
    t_capture;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule